// File: doc/BRIEF.md
# Sequential 32-bit Integer Divider with Overflow Flags

This block divides one 32-bit operand by another and returns only the quotient. It produces one quotient bit per clock, so a normal division keeps the unit busy for 32 cycles. The caller selects signed or unsigned arithmetic and whether overflow is reported. Operands whose quotient has no defined value are a zero divisor in either mode, or the most negative signed value divided by minus one. The block detects these at the start and returns zero in a single cycle. It does not trap on them.

A completion can update two flags. The overflow flag reflects the most recent completion made with reporting enabled. The summary flag is sticky: it collects every reported overflow until software clears it through a dedicated input. Only one division is in flight at a time. A start request that arrives while the unit is busy is dropped.

Top module: `int_seq_divider`

## Requirements
- R1: In unsigned mode (`signed_i`=0) with a non-zero divisor, `quotient_o` equals the dividend divided by the divisor, rounded down. This includes dividend 0x80000000 with divisor 0xFFFFFFFF (quotient 0) and 0xFFFFFFFF divided by itself (quotient 1).
- R2: In signed mode (`signed_i`=1), operands are two's complement and the quotient truncates toward zero. For example, -7/2 gives -3 (0xFFFFFFFD).
- R3: A zero divisor gives a quotient of 0 in both modes.
- R4: In signed mode, dividend 0x80000000 with divisor 0xFFFFFFFF gives a quotient of 0.
- R5: An accepted normal division holds `busy_o` high for exactly 32 cycles after the accepting clock edge. `done_o` then pulses for one cycle, in the cycle after `busy_o` falls, and the new `quotient_o` appears in that same cycle. `quotient_o` holds its value until the next completion.
- R6: A forced-zero case (R3, R4) raises `done_o` in the cycle right after the accepting edge, and `busy_o` never rises for it.
- R7: With `ovf_en_i`=1 at start, a forced-zero completion sets both `ovf_o` and `so_o`. A normal completion clears `ovf_o` and leaves `so_o` unchanged.
- R8: With `ovf_en_i`=0 at start, a completion changes neither `ovf_o` nor `so_o`.
- R9: `so_o` stays set until `so_clr_i` is high at a clock edge. If an overflow is set at the same edge as the clear, the set wins.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running division completes at its original time with its original quotient.
- R11: After reset, `busy_o`, `done_o`, `ovf_o` and `so_o` are 0, and `quotient_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; accepted when not busy |
| signed_i | input | 1 | 1 = two's complement operands |
| ovf_en_i | input | 1 | 1 = completion updates the overflow flags |
| so_clr_i | input | 1 | Clear the sticky summary flag |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Last quotient |
| ovf_o | output | 1 | Overflow of the last reporting completion |
| so_o | output | 1 | Sticky summary overflow |

## Verification
The summary-flag clear and an overflow set can land on the same clock edge. The bench provokes this by raising `so_clr_i` in the same cycle as a start that carries a zero divisor with reporting enabled. Because the forced-zero path completes at the accepting edge, set and clear coincide there, and the bench expects `so_o` to remain 1. A second collision comes from a start request made while an iteration is running. The bench judges it through the per-cycle reference model, which expects unchanged `busy_o` timing and the first operation's quotient.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned DIV_W = 32;

  typedef enum logic [1:0] {
    CASE_NORMAL   = 2'd0,
    CASE_ZERO_DEN = 2'd1,
    CASE_SGN_OVF  = 2'd2
  } div_case_e;
endpackage

// File: rtl/div_classify.sv
module div_classify
  import div_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic         signed_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output div_case_e    case_o,
  output logic [W-1:0] num_mag_o,
  output logic [W-1:0] den_mag_o,
  output logic         neg_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic num_neg, den_neg;

  always_comb begin
    num_neg   = signed_i & num_i[W-1];
    den_neg   = signed_i & den_i[W-1];
    num_mag_o = num_neg ? (~num_i + 1'b1) : num_i;
    den_mag_o = den_neg ? (~den_i + 1'b1) : den_i;
    neg_o     = num_neg ^ den_neg;
    if (den_i == '0)
      case_o = CASE_ZERO_DEN;
    else if (signed_i && num_i == MOST_NEG && den_i == ALL_ONES)
      case_o = CASE_SGN_OVF;
    else
      case_o = CASE_NORMAL;
  end
endmodule

// File: rtl/div_iter.sv
module div_iter
  import div_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] num_mag_i,
  input  logic [W-1:0] den_mag_i,
  input  logic         neg_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] q_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W:0]    rem_q, rem_sh, diff, rem_nx;
  logic [W-1:0]  quo_q, den_q, quo_nx;
  logic          neg_q, take;

  assign busy_o = (cnt_q != '0);
  assign fin_o  = (cnt_q == CW'(1));

  // restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    rem_sh = {rem_q[W-1:0], quo_q[W-1]};
    diff   = rem_sh - {1'b0, den_q};
    take   = ~diff[W];
    rem_nx = take ? diff : rem_sh;
    quo_nx = {quo_q[W-2:0], take};
    q_o    = neg_q ? (~quo_nx + 1'b1) : quo_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      neg_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= CW'(W);
      rem_q <= '0;
      quo_q <= num_mag_i;
      den_q <= den_mag_i;
      neg_q <= neg_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
      rem_q <= rem_nx;
      quo_q <= quo_nx;
    end
  end

  assert_load_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  assert_fin_ends_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o);
  assert_load_starts_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_o && !fin_o));
endmodule

// File: rtl/div_flags.sv
module div_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic en_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic so_o
);
  logic set_so;

  assign set_so = upd_i & en_i & hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      so_o  <= 1'b0;
    end else begin
      if (upd_i && en_i) ovf_o <= hit_i;
      // set beats clear
      if (set_so)      so_o <= 1'b1;
      else if (clr_i)  so_o <= 1'b0;
    end
  end

  assert_ovf_sets_so_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && en_i && hit_i) |=> (ovf_o && so_o));
  assert_so_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_o && !clr_i) |=> so_o);
  assert_no_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && en_i) |=> $stable(ovf_o));
endmodule

// File: rtl/int_seq_divider.sv
module int_seq_divider
  import div_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic         ovf_en_i,
  input  logic         so_clr_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic         ovf_o,
  output logic         so_o
);
  div_case_e    cls;
  logic [W-1:0] num_mag, den_mag, core_q;
  logic         neg, accept, special, core_fin, ovf_en_q;
  logic         flag_upd, flag_en;

  div_classify #(.W(W)) u_classify (
    .signed_i  (signed_i),
    .num_i     (dividend_i),
    .den_i     (divisor_i),
    .case_o    (cls),
    .num_mag_o (num_mag),
    .den_mag_o (den_mag),
    .neg_o     (neg)
  );

  assign accept  = start_i & ~busy_o;
  assign special = (cls != CASE_NORMAL);

  div_iter #(.W(W)) u_iter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept & ~special),
    .num_mag_i (num_mag),
    .den_mag_i (den_mag),
    .neg_i     (neg),
    .busy_o    (busy_o),
    .fin_o     (core_fin),
    .q_o       (core_q)
  );

  assign flag_upd = core_fin | (accept & special);
  assign flag_en  = core_fin ? ovf_en_q : ovf_en_i;

  div_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (flag_upd),
    .en_i   (flag_en),
    .hit_i  (accept & special),
    .clr_i  (so_clr_i),
    .ovf_o  (ovf_o),
    .so_o   (so_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      quotient_o <= '0;
      ovf_en_q   <= 1'b0;
    end else begin
      done_o <= flag_upd;
      if (accept && !special) ovf_en_q <= ovf_en_i;
      if (core_fin)                quotient_o <= core_q;
      else if (accept && special)  quotient_o <= '0;
    end
  end

  assert_forced_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && special) |=> (done_o && quotient_o == '0 && !busy_o));
  assert_quotient_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !core_fin) |=> ($stable(quotient_o) && !done_o));
  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !core_fin) |=> busy_o);
  assert_done_not_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/int_seq_divider_bench.sv
`timescale 1ns/1ps
module int_seq_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0, oen = 1'b0, so_clr = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done, ovf, so;
  logic [31:0] quo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  int_seq_divider u_int_seq_divider (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .ovf_en_i(oen), .so_clr_i(so_clr), .dividend_i(a), .divisor_i(b),
    .busy_o(busy), .done_o(done), .quotient_o(quo), .ovf_o(ovf), .so_o(so)
  );

  // behavioural reference model
  int          m_cnt;
  logic        m_done, m_ovf, m_so, m_poen;
  logic [31:0] m_q, m_pq;

  function automatic logic is_special(logic s, logic [31:0] x, logic [31:0] y);
    return (y == 0) || (s && x == 32'h8000_0000 && y == 32'hFFFF_FFFF);
  endfunction

  function automatic logic [31:0] ref_div(logic s, logic [31:0] x, logic [31:0] y);
    if (is_special(s, x, y)) return 32'd0;
    if (s) return $unsigned($signed(x) / $signed(y));
    return x / y;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_ovf = 0; m_so = 0; m_q = 0; m_pq = 0; m_poen = 0;
    end else begin
      logic set_so;
      set_so = 1'b0;
      m_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1'b1; m_q = m_pq;
          if (m_poen) m_ovf = 1'b0;
        end
      end else if (start) begin
        if (is_special(sgn, a, b)) begin
          m_done = 1'b1; m_q = 0;
          if (oen) begin m_ovf = 1'b1; set_so = 1'b1; end
        end else begin
          m_cnt = 32; m_pq = ref_div(sgn, a, b); m_poen = oen;
        end
      end
      if (set_so) m_so = 1'b1;
      else if (so_clr) m_so = 1'b0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk("R5 busy", {31'd0, busy}, {31'd0, m_cnt > 0});
      chk("R5 done", {31'd0, done}, {31'd0, m_done});
      chk("R1 quotient", quo, m_q);
      chk("R7 ovf", {31'd0, ovf}, {31'd0, m_ovf});
      chk("R9 so", {31'd0, so}, {31'd0, m_so});
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  // run one op; intrude=1 pulses start with other operands mid-run
  task automatic run(string tag, logic s, logic e, logic [31:0] x, logic [31:0] y,
                     logic [31:0] exp_q, logic intrude = 1'b0, logic clr = 1'b0);
    int n;
    logic sp;
    sp = is_special(s, x, y);
    @(negedge clk);
    start = 1; sgn = s; oen = e; a = x; b = y; so_clr = clr;
    n = 0;
    do begin
      @(negedge clk);
      start = 0; so_clr = 0;
      n++;
      if (intrude && n == 10) begin
        start = 1; sgn = 0; oen = 1; a = 32'd9; b = 32'd0;
      end
    end while (!done && n < 100);
    chk({tag, " quotient"}, quo, exp_q);
    chk(sp ? "R6 latency" : "R5 latency", n, sp ? 1 : 33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 busy", {31'd0, busy}, 0);
    chk("R11 done", {31'd0, done}, 0);
    chk("R11 quotient", quo, 0);
    chk("R11 ovf", {31'd0, ovf}, 0);
    chk("R11 so", {31'd0, so}, 0);

    run("R1 100/7", 0, 0, 32'd100, 32'd7, 32'd14);
    run("R1 max/1", 0, 0, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF);
    run("R1 max/max", 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1);
    run("R1 unsigned minneg/-1", 0, 1, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0);
    chk("R7 normal clears ovf", {31'd0, ovf}, 0);
    run("R2 -7/2", 1, 0, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFD);
    run("R2 7/-2", 1, 0, 32'd7, 32'hFFFF_FFFE, 32'hFFFF_FFFD);
    run("R2 -100/-10", 1, 0, 32'hFFFF_FF9C, 32'hFFFF_FFF6, 32'd10);
    run("R2 minneg/2", 1, 0, 32'h8000_0000, 32'd2, 32'hC000_0000);

    run("R8 zero den no report", 1, 0, 32'd5, 32'd0, 32'd0);
    chk("R8 ovf unchanged", {31'd0, ovf}, 0);
    chk("R8 so unchanged", {31'd0, so}, 0);

    run("R3 signed zero den", 1, 1, 32'd5, 32'd0, 32'd0);
    chk("R7 ovf set", {31'd0, ovf}, 1);
    chk("R7 so set", {31'd0, so}, 1);
    run("R7 normal after ovf", 0, 1, 32'd50, 32'd5, 32'd10);
    chk("R7 ovf cleared", {31'd0, ovf}, 0);
    chk("R7 so kept", {31'd0, so}, 1);

    @(negedge clk); so_clr = 1;
    @(negedge clk); so_clr = 0;
    chk("R9 so cleared", {31'd0, so}, 0);

    run("R4 signed minneg/-1", 1, 1, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0);
    chk("R4 ovf", {31'd0, ovf}, 1);
    run("R3 unsigned zero den", 0, 0, 32'd77, 32'd0, 32'd0);

    @(negedge clk); so_clr = 1;
    @(negedge clk); so_clr = 0;
    run("R9 set with clear", 0, 1, 32'd3, 32'd0, 32'd0, 1'b0, 1'b1);
    chk("R9 set beats clear", {31'd0, so}, 1);

    run("R10 start while busy", 0, 0, 32'd1000, 32'd3, 32'd333, 1'b1);
    @(negedge clk);
    chk("R10 no restart busy", {31'd0, busy}, 0);
    chk("R5 quotient held", quo, 32'd333);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule